// File: doc/BRIEF.md
# Paged Memory Chip-Select Decoder

This block turns a 16-bit CPU bus address and the active bus strobe into one-hot chip selects for a small paged memory system. Instruction fetches, marked by the program strobe, are steered to one of eight 16 KB main-flash sectors. Data reads and writes, marked by the read and write strobes, are steered to one of four 8 KB secondary-flash segments, to an 8 KB SRAM, or to a 256-byte control-register block.

The lower half of program space always shows the same two main sectors. The upper half shows a pair of sectors chosen by an 8-bit page register, which software loads by a data write to a fixed location inside the control-register block. All selects are registered, so a select is valid in the clock cycle after the address and strobe that caused it.

Top module: `pgdec_top`

## Requirements
- R1: After a synchronous reset every select output is low and the page register holds 0, so a fetch from C000h right after reset selects main sector 3.
- R2: Each select output is registered: it reflects the address and strobes sampled at the previous rising clock edge and does not change between edges.
- R3: A fetch from 0000h–3FFFh selects main sector 0 (main_cs bit 0) and a fetch from 4000h–7FFFh selects main sector 1 (bit 1), whatever the page value.
- R4: A fetch from 8000h–BFFFh selects main sector 2, 4 or 6 and a fetch from C000h–FFFFh selects main sector 3, 5 or 7, for page values 0, 1 and 2 respectively.
- R5: With a page value of 3 or more, a fetch from the upper half of program space asserts no select.
- R6: A data read or write in 8000h–9FFFh, A000h–BFFFh, C000h–DFFFh or E000h–FFFFh asserts sec_cs bit 0, 1, 2 or 3 respectively.
- R7: A data access in 0000h–1FFFh asserts sram_cs; a data access in 2000h–20FFh asserts reg_cs.
- R8: A data access in 2100h–7FFFh asserts no select.
- R9: A write strobe without the program strobe at address 2010h loads bus_wdata into the page register at that clock edge, and the next fetch uses the new value; reads of 2010h, writes to other addresses, and writes that coincide with the program strobe leave the page unchanged.
- R10: At most one select is high in any cycle; when the program strobe is active together with a data strobe, only program space is decoded.
- R11: When no strobe is active, every select is low in the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | 16 | CPU address |
| prog_stb | input | 1 | Program-fetch strobe, active high |
| rd_stb | input | 1 | Data read strobe, active high |
| wr_stb | input | 1 | Data write strobe, active high |
| bus_wdata | input | 8 | Write data, used to load the page register |
| main_cs | output | 8 | One-hot main-flash sector selects, bit n for sector n |
| sec_cs | output | 4 | One-hot secondary-flash segment selects |
| sram_cs | output | 1 | SRAM select |
| reg_cs | output | 1 | Control-register block select |

## Verification
The page-register load and the register-block select happen on the same edge: a write to 2010h must raise reg_cs while the page changes underneath, and a fetch issued in the very next cycle must already use the new page. The bench provokes this with back-to-back write-then-fetch pairs, both directed and inside the random stream, and judges it against a bench model whose page variable is updated only after that edge's expected value is taken. Strobe collisions (program with write to 2010h) are also driven to confirm the fetch wins and the page stays put.

// File: rtl/pgdec_pkg.sv
package pgdec_pkg;

  typedef enum logic [1:0] {
    ACC_NONE = 2'd0,
    ACC_PROG = 2'd1,
    ACC_DATA = 2'd2
  } acc_e;

  // Program strobe outranks the data strobes.
  function automatic acc_e classify(input logic prog, input logic rd, input logic wr);
    if (prog)          return ACC_PROG;
    else if (rd || wr) return ACC_DATA;
    else               return ACC_NONE;
  endfunction

endpackage

// File: rtl/pgdec_page_reg.sv
module pgdec_page_reg #(
  parameter int ADDR_W    = 16,
  parameter int PAGE_W    = 8,
  parameter int PAGE_ADDR = 16'h2010
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [PAGE_W-1:0] wdata,
  output logic [PAGE_W-1:0] page
);

  localparam logic [ADDR_W-1:0] HIT_ADDR = ADDR_W'(PAGE_ADDR);

  logic hit;
  assign hit = wr_en && (addr == HIT_ADDR);

  always_ff @(posedge clk) begin
    if (rst)      page <= '0;
    else if (hit) page <= wdata;
  end

endmodule

// File: rtl/pgdec_prog_map.sv
module pgdec_prog_map #(
  parameter int MAIN_SECTS = 8,
  parameter int PAGE_W     = 8
) (
  input  logic                  fetch,
  input  logic [1:0]            top_bits,
  input  logic [PAGE_W-1:0]     page,
  output logic [MAIN_SECTS-1:0] sel
);

  localparam int COMMON = 2;
  localparam int SLOTS  = 2;

  logic upper;
  logic slot_bit;
  assign upper    = top_bits[1];
  assign slot_bit = top_bits[0];

  for (genvar i = 0; i < MAIN_SECTS; i++) begin : g_sect
    if (i < COMMON) begin : g_common
      assign sel[i] = fetch && !upper && (slot_bit == 1'(i));
    end else begin : g_paged
      localparam int PG = (i - COMMON) / SLOTS;
      localparam int SL = (i - COMMON) % SLOTS;
      assign sel[i] = fetch && upper && (page == PAGE_W'(PG)) && (slot_bit == 1'(SL));
    end
  end

endmodule

// File: rtl/pgdec_data_map.sv
module pgdec_data_map #(
  parameter int ADDR_W     = 16,
  parameter int SEC_SEGS   = 4,
  parameter int SRAM_BYTES = 8192,
  parameter int REG_BASE   = 16'h2000,
  parameter int REG_BYTES  = 256
) (
  input  logic                access,
  input  logic [ADDR_W-1:0]   addr,
  output logic [SEC_SEGS-1:0] sec_sel,
  output logic                sram_sel,
  output logic                reg_sel
);

  localparam int SEG_W     = $clog2(SEC_SEGS);
  localparam int REG_SH    = $clog2(REG_BYTES);
  localparam int REG_TAG_W = ADDR_W - REG_SH;
  localparam logic [REG_TAG_W-1:0] REG_TAG   = REG_TAG_W'(REG_BASE >> REG_SH);
  localparam logic [ADDR_W-1:0]    SRAM_TOP  = ADDR_W'(SRAM_BYTES);

  logic             upper;
  logic [SEG_W-1:0] seg_idx;
  assign upper   = addr[ADDR_W-1];
  assign seg_idx = addr[ADDR_W-2 -: SEG_W];

  for (genvar j = 0; j < SEC_SEGS; j++) begin : g_seg
    assign sec_sel[j] = access && upper && (seg_idx == SEG_W'(j));
  end

  assign sram_sel = access && (addr < SRAM_TOP);
  assign reg_sel  = access && (addr[ADDR_W-1:REG_SH] == REG_TAG);

endmodule

// File: rtl/pgdec_top.sv
module pgdec_top #(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 8,
  parameter int MAIN_SECTS = 8,
  parameter int SEC_SEGS   = 4,
  parameter int SRAM_BYTES = 8192,
  parameter int REG_BASE   = 16'h2000,
  parameter int REG_BYTES  = 256,
  parameter int PAGE_OFS   = 16'h0010
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic                  prog_stb,
  input  logic                  rd_stb,
  input  logic                  wr_stb,
  input  logic [DATA_W-1:0]     bus_wdata,
  output logic [MAIN_SECTS-1:0] main_cs,
  output logic [SEC_SEGS-1:0]   sec_cs,
  output logic                  sram_cs,
  output logic                  reg_cs
);
  import pgdec_pkg::*;

  localparam int PAGE_ADDR = REG_BASE + PAGE_OFS;
  localparam int NUM_PAGES = (MAIN_SECTS - 2) / 2;
  localparam logic [ADDR_W-1:0] PAGE_ADDR_V = ADDR_W'(PAGE_ADDR);

  acc_e              acc;
  logic              is_fetch;
  logic              is_data;
  logic [DATA_W-1:0] page_q;
  logic [MAIN_SECTS-1:0] main_d;
  logic [SEC_SEGS-1:0]   sec_d;
  logic              sram_d;
  logic              reg_d;

  assign acc      = classify(prog_stb, rd_stb, wr_stb);
  assign is_fetch = (acc == ACC_PROG);
  assign is_data  = (acc == ACC_DATA);

  pgdec_page_reg #(
    .ADDR_W    (ADDR_W),
    .PAGE_W    (DATA_W),
    .PAGE_ADDR (PAGE_ADDR)
  ) u_page (
    .clk   (clk),
    .rst   (rst),
    .wr_en (is_data && wr_stb),
    .addr  (bus_addr),
    .wdata (bus_wdata),
    .page  (page_q)
  );

  pgdec_prog_map #(
    .MAIN_SECTS (MAIN_SECTS),
    .PAGE_W     (DATA_W)
  ) u_prog (
    .fetch    (is_fetch),
    .top_bits (bus_addr[ADDR_W-1 -: 2]),
    .page     (page_q),
    .sel      (main_d)
  );

  pgdec_data_map #(
    .ADDR_W     (ADDR_W),
    .SEC_SEGS   (SEC_SEGS),
    .SRAM_BYTES (SRAM_BYTES),
    .REG_BASE   (REG_BASE),
    .REG_BYTES  (REG_BYTES)
  ) u_data (
    .access   (is_data),
    .addr     (bus_addr),
    .sec_sel  (sec_d),
    .sram_sel (sram_d),
    .reg_sel  (reg_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      main_cs <= '0;
      sec_cs  <= '0;
      sram_cs <= 1'b0;
      reg_cs  <= 1'b0;
    end else begin
      main_cs <= main_d;
      sec_cs  <= sec_d;
      sram_cs <= sram_d;
      reg_cs  <= reg_d;
    end
  end

  // Checks armed once one decode cycle has followed reset.
  logic chk_armed;
  always_ff @(posedge clk) begin
    if (rst) chk_armed <= 1'b0;
    else     chk_armed <= 1'b1;
  end

  // R10
  cs_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({reg_cs, sram_cs, sec_cs, main_cs}));

  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (chk_armed && !$past(prog_stb || rd_stb || wr_stb))
      |-> ({reg_cs, sram_cs, sec_cs, main_cs} == '0));

  // R3
  common_low_chk: assert property (@(posedge clk) disable iff (rst)
    (chk_armed && $past(prog_stb) && !$past(bus_addr[ADDR_W-1]))
      |-> (main_cs[1:0] != 2'b00));

  // R5
  bad_page_chk: assert property (@(posedge clk) disable iff (rst)
    (chk_armed && $past(prog_stb) && $past(bus_addr[ADDR_W-1]) &&
     ($past(page_q) >= DATA_W'(NUM_PAGES)))
      |-> (main_cs == '0));

  // R6
  seg_pick_chk: assert property (@(posedge clk) disable iff (rst)
    (chk_armed && $past(!prog_stb && (rd_stb || wr_stb)) && $past(bus_addr[ADDR_W-1]))
      |-> $onehot(sec_cs));

  // R9
  page_load_chk: assert property (@(posedge clk) disable iff (rst)
    (chk_armed && $past(wr_stb && !prog_stb && (bus_addr == PAGE_ADDR_V)))
      |-> (page_q == $past(bus_wdata)));

endmodule

// File: tb/pgdec_top_tb.sv
`timescale 1ns/100ps
module pgdec_top_tb;

  logic        clk = 1'b0;
  logic        rst;
  logic [15:0] bus_addr;
  logic        prog_stb, rd_stb, wr_stb;
  logic [7:0]  bus_wdata;
  logic [7:0]  main_cs;
  logic [3:0]  sec_cs;
  logic        sram_cs, reg_cs;

  int  n_checks = 0;
  int  n_fails  = 0;
  bit  finished = 0;
  logic [7:0] mpage = 8'd0;

  always #2.5 clk = ~clk;

  pgdec_top u_dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .prog_stb(prog_stb),
    .rd_stb(rd_stb), .wr_stb(wr_stb), .bus_wdata(bus_wdata),
    .main_cs(main_cs), .sec_cs(sec_cs), .sram_cs(sram_cs), .reg_cs(reg_cs)
  );

  // Vector layout: {reg, sram, sec[3:0], main[7:0]}
  function automatic logic [13:0] expv(logic [15:0] a, bit ps, bit rd, bit wr, logic [7:0] pg);
    logic [13:0] v = '0;
    if (ps) begin
      if (!a[15]) v[int'(a[14])] = 1'b1;
      else if (pg < 8'd3) v[2 + 2*int'(pg) + int'(a[14])] = 1'b1;
    end else if (rd || wr) begin
      if (a[15]) v[8 + int'(a[14:13])] = 1'b1;
      else if (a < 16'h2000) v[12] = 1'b1;
      else if (a[15:8] == 8'h20) v[13] = 1'b1;
    end
    return v;
  endfunction

  function automatic logic [13:0] got();
    return {reg_cs, sram_cs, sec_cs, main_cs};
  endfunction

  task automatic check(string tag, logic [13:0] act, logic [13:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: got %014b expected %014b", tag, act, exp);
    end
  endtask

  task automatic step(string tag, logic [15:0] a, bit ps, bit rd, bit wr, logic [7:0] d);
    logic [13:0] e;
    @(negedge clk);
    bus_addr = a; prog_stb = ps; rd_stb = rd; wr_stb = wr; bus_wdata = d;
    e = expv(a, ps, rd, wr, mpage);
    @(posedge clk);
    if (wr && !ps && a == 16'h2010) mpage = d;
    #1;
    check(tag, got(), e);
  endtask

  task automatic idle();
    step("R11", 16'h0000, 0, 0, 0, 8'h00);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++; n_fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    rst = 1'b1; bus_addr = 16'h0; prog_stb = 0; rd_stb = 0; wr_stb = 0; bus_wdata = 8'h0;
    repeat (3) @(posedge clk);
    #1;
    // R1: selects low while and after reset
    check("R1 reset", got(), 14'd0);
    @(negedge clk); rst = 1'b0;
    @(posedge clk); #1;
    check("R1 after reset", got(), 14'd0);
    // R1: page starts at 0 -> C000h fetch selects sector 3
    step("R1 page0", 16'hC000, 1, 0, 0, 8'h00);
    check("R1 fs3", got(), 14'b00_0000_00001000);

    // R2: output holds until next edge
    @(negedge clk);
    bus_addr = 16'h8000; prog_stb = 0; rd_stb = 1; wr_stb = 0;
    #1;
    check("R2 hold", got(), 14'b00_0000_00001000);
    @(posedge clk); #1;
    check("R2 update", got(), 14'b00_0001_00000000);

    // R3 common sectors on page 0
    step("R3", 16'h0000, 1, 0, 0, 0);
    step("R3", 16'h3FFF, 1, 0, 0, 0);
    step("R3", 16'h4000, 1, 0, 0, 0);
    step("R3", 16'h7FFF, 1, 0, 0, 0);

    // R4 upper half per page, with R9 back-to-back load then fetch
    for (int p = 0; p < 3; p++) begin
      step("R9 load", 16'h2010, 0, 0, 1, 8'(p));
      step("R4", 16'h8000, 1, 0, 0, 0);
      step("R4", 16'hBFFF, 1, 0, 0, 0);
      step("R4", 16'hC000, 1, 0, 0, 0);
      step("R4", 16'hFFFF, 1, 0, 0, 0);
      step("R3", 16'h1234, 1, 0, 0, 0);
      step("R3", 16'h5678, 1, 0, 0, 0);
    end
    check("R4 page2 fs6", expv(16'h8000, 1, 0, 0, 8'd2), 14'b00_0000_01000000);

    // R5 unsupported pages
    step("R9 load", 16'h2010, 0, 0, 1, 8'd3);
    step("R5", 16'h8000, 1, 0, 0, 0);
    check("R5 none", got(), 14'd0);
    step("R5", 16'hFFFF, 1, 0, 0, 0);
    step("R3", 16'h4000, 1, 0, 0, 0);
    step("R9 load", 16'h2010, 0, 0, 1, 8'hFF);
    step("R5", 16'hC123, 1, 0, 0, 0);

    // R9 non-loading accesses
    step("R9 load", 16'h2010, 0, 0, 1, 8'd1);
    step("R9 read", 16'h2010, 0, 1, 0, 8'd2);
    step("R9 other", 16'h2011, 0, 0, 1, 8'd2);
    step("R9 collide", 16'h2010, 1, 0, 1, 8'd2);
    step("R9 page kept", 16'hC000, 1, 0, 0, 0);
    check("R9 fs5", got(), 14'b00_0000_00100000);

    // R6 secondary segments
    step("R6", 16'h8000, 0, 1, 0, 0);
    step("R6", 16'h9FFF, 0, 0, 1, 0);
    step("R6", 16'hA000, 0, 1, 0, 0);
    step("R6", 16'hDFFF, 0, 1, 0, 0);
    step("R6", 16'hE000, 0, 0, 1, 0);
    step("R6", 16'hFFFF, 0, 1, 0, 0);
    check("R6 seg3", got(), 14'b00_1000_00000000);

    // R7 SRAM and register block
    step("R7", 16'h0000, 0, 1, 0, 0);
    step("R7", 16'h1FFF, 0, 0, 1, 0);
    step("R7", 16'h2000, 0, 1, 0, 0);
    step("R7", 16'h20FF, 0, 0, 1, 0);
    check("R7 reg", got(), 14'b10_0000_00000000);

    // R8 hole
    step("R8", 16'h2100, 0, 1, 0, 0);
    step("R8", 16'h4000, 0, 0, 1, 0);
    step("R8", 16'h7FFF, 0, 1, 0, 0);
    check("R8 none", got(), 14'd0);

    // R10 strobe priority
    step("R10", 16'h8000, 1, 1, 0, 0);
    step("R10", 16'h1000, 1, 0, 1, 0);
    step("R10", 16'h1000, 0, 1, 1, 0);

    // R11 idle with busy address
    @(negedge clk); bus_addr = 16'hC000; prog_stb = 0; rd_stb = 0; wr_stb = 0;
    @(posedge clk); #1;
    check("R11", got(), 14'd0);
    idle();

    // Random mix, fixed seed
    void'($urandom(32'h5EED_1234));
    for (int k = 0; k < 4000; k++) begin
      int sel;
      logic [15:0] a;
      a = 16'($urandom);
      sel = int'($urandom % 10);
      case (sel)
        0:       step("R11 rnd", a, 0, 0, 0, 8'($urandom));
        1, 2, 3: step("R4 rnd", a, 1, 0, 0, 0);
        4, 5:    step("R6 rnd", a, 0, 1, 0, 0);
        6:       step("R7 rnd", a, 0, 0, 1, 8'($urandom));
        7:       step("R9 rnd", 16'h2010, 0, 0, 1, 8'($urandom % 5));
        8:       step("R10 rnd", a, 1, $urandom % 2 == 0, $urandom % 2 == 0, 8'($urandom % 5));
        default: step("R10 rnd", a, 0, 1, 1, 8'($urandom % 5));
      endcase
    end

    finish_run();
  end

endmodule